// File: doc/BRIEF.md
# Threshold-Driven Data Buffer with DMA Requests

This block is a circular buffer of halfword entries. It sits between a host register port and a card-side transfer engine. The transfer direction picks who fills and who drains it. In transmit, the host writes the data port and the engine takes entries. In receive, the engine deposits entries and the host reads them back through the data port. Two programmable occupancy levels are held in a configuration register. Comparing the current occupancy against them yields one request per direction. A per-direction DMA enable decides whether that request goes to a DMA request line or to a CPU-visible status flag.

The buffer outputs are derived every cycle from the registered occupancy and configuration, so they are levels and not sticky events. When no transfer is running and the buffer is empty, every request and flag is held low whatever the levels say.

Push interfaces use valid/ready. A push is taken on a clock edge where valid and ready are both high. Ready drops when all entries are occupied, and a push offered then is dropped rather than stalled by the block. On the transmit drain side, the engine sees `eng_pop_valid` while the buffer holds data, and it takes the head when it raises `eng_pop_ready`. The host read is a plain strobe: `hrd_data` always shows the head entry, and a strobe removes that entry only in receive mode with data present.

Top module: `tfifo_dma_buf`

## Requirements
- R1: After reset the buffer is empty and `cfg_rdata` reads 16'h1F00: upper level 31, lower level 0, both DMA enables off.
- R2: Entries leave in the order they were accepted. Storage is a ring of 32 halfwords whose indices wrap modulo 32.
- R3: With 32 entries held, push ready is low, and an offered push changes neither contents nor occupancy.
- R4: A host read strobe on an empty buffer returns the entry at the ring head and removes nothing.
- R5: In receive mode (`dir_rx`=1), the receive condition is occupancy strictly greater than the upper level. When it holds, `dma_rx_req` is high if config bit 15 is set; otherwise `st_rx_level` is high. When it does not hold, both are low.
- R6: In transmit mode, the transmit condition is occupancy strictly less than the lower level. When it holds, `dma_tx_req` is high if config bit 7 is set; otherwise `st_tx_level` is high. When it does not hold, both are low.
- R7: When `xfer_active` is low and the buffer is empty, all four request and flag outputs are low.
- R8: The configuration register layout is: bit 15 receive DMA enable, bits 12:8 upper level, bit 7 transmit DMA enable, bits 4:0 lower level. Other bits read as 0. A write takes effect on the next cycle, so setting an enable clears the matching status flag from that cycle on.
- R9: A push and a pop accepted in the same cycle leave the occupancy unchanged, and the popped entry is the old head.
- R10: In transmit mode only the host can push and only the engine can pop. In receive mode only the engine can push and only the host read strobe can pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xfer_active | input | 1 | A card transfer is in progress |
| dir_rx | input | 1 | 1 = receive (card to host), 0 = transmit |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 16 | Configuration write value |
| cfg_rdata | output | 16 | Configuration register read value |
| hwr_valid | input | 1 | Host data-port write offered |
| hwr_data | input | 16 | Host write halfword |
| hwr_ready | output | 1 | Host write can be accepted |
| hrd_en | input | 1 | Host data-port read strobe |
| hrd_data | output | 16 | Head entry seen by the host |
| eng_push_valid | input | 1 | Engine receive halfword offered |
| eng_push_data | input | 16 | Engine receive halfword |
| eng_push_ready | output | 1 | Engine push can be accepted |
| eng_pop_valid | output | 1 | Transmit halfword available to the engine |
| eng_pop_data | output | 16 | Transmit halfword (head entry) |
| eng_pop_ready | input | 1 | Engine takes the head entry |
| dma_rx_req | output | 1 | Receive DMA request |
| dma_tx_req | output | 1 | Transmit DMA request |
| st_rx_level | output | 1 | Receive level status flag |
| st_tx_level | output | 1 | Transmit level status flag |

## Verification
The bench builds the block at its default 32-entry, 16-bit size. At that size every occupancy from empty to full can be visited in each direction. For several lower and upper level settings, with each DMA enable both on and off, it fills the buffer to full and drains it back, checking the four level outputs against the arithmetic comparison at every step. The walk starts from an offset ring head, so wrap-around of the indices is covered, along with the full-push discard, the empty read and the idle gate.

// File: rtl/tfifo_pkg.sv
package tfifo_pkg;
  // Level fields are five bits wide; their bit positions are fixed by R8.
  localparam int LVL_W      = 5;
  localparam int CFG_W      = 16;
  localparam int RXEN_BIT   = 15;
  localparam int AF_LSB     = 8;
  localparam int TXEN_BIT   = 7;
  localparam int AE_LSB     = 0;

  typedef struct packed {
    logic             rx_dma;
    logic [LVL_W-1:0] hi_lvl;
    logic             tx_dma;
    logic [LVL_W-1:0] lo_lvl;
  } buf_cfg_t;
endpackage

// File: rtl/tfifo_cfg.sv
module tfifo_cfg
  import tfifo_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output buf_cfg_t         cfg,
  output logic [CFG_W-1:0] rdata
);
  localparam logic [LVL_W-1:0] HI_RST = LVL_W'(DEPTH - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg.rx_dma <= 1'b0;
      cfg.hi_lvl <= HI_RST;
      cfg.tx_dma <= 1'b0;
      cfg.lo_lvl <= '0;
    end else if (we) begin
      cfg.rx_dma <= wdata[RXEN_BIT];
      cfg.hi_lvl <= wdata[AF_LSB +: LVL_W];
      cfg.tx_dma <= wdata[TXEN_BIT];
      cfg.lo_lvl <= wdata[AE_LSB +: LVL_W];
    end
  end

  always_comb begin
    rdata                   = '0;
    rdata[RXEN_BIT]         = cfg.rx_dma;
    rdata[AF_LSB +: LVL_W]  = cfg.hi_lvl;
    rdata[TXEN_BIT]         = cfg.tx_dma;
    rdata[AE_LSB +: LVL_W]  = cfg.lo_lvl;
  end

  // R8
  rx_enable_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (cfg.rx_dma == $past(wdata[RXEN_BIT])) && (cfg.tx_dma == $past(wdata[TXEN_BIT])));

  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(rdata));
endmodule

// File: rtl/tfifo_store.sv
module tfifo_store #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   push_req,
  input  logic [WIDTH-1:0]       push_data,
  input  logic                   pop_req,
  output logic [WIDTH-1:0]       head_data,
  output logic [$clog2(DEPTH):0] count,
  output logic                   full,
  output logic                   empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    rd_ptr;
  logic [AW-1:0]    wr_idx;
  logic             push_do;
  logic             pop_do;

  assign full      = (count == FULL_CNT);
  assign empty     = (count == '0);
  assign push_do   = push_req && !full;
  assign pop_do    = pop_req && !empty;
  assign wr_idx    = rd_ptr + count[AW-1:0];
  assign head_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_do) mem[wr_idx] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (pop_do) rd_ptr <= rd_ptr + 1'b1;
      case ({push_do, pop_do})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push_req && !pop_req) |=> full);

  // R4
  no_underrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop_req && !push_req) |=> (empty && $stable(rd_ptr)));

  // R9
  push_pop_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && pop_req && !full && !empty) |=> $stable(count));
endmodule

// File: rtl/tfifo_level.sv
module tfifo_level
  import tfifo_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [$clog2(DEPTH):0] count,
  input  buf_cfg_t               cfg,
  input  logic                   xfer_active,
  input  logic                   dir_rx,
  output logic                   dma_rx_req,
  output logic                   dma_tx_req,
  output logic                   st_rx_level,
  output logic                   st_tx_level
);
  localparam int CW = $clog2(DEPTH) + 1;

  logic idle_gate;
  logic rx_hit;
  logic tx_hit;

  assign idle_gate = !xfer_active && (count == '0);
  assign rx_hit    = !idle_gate &&  dir_rx && (count > CW'(cfg.hi_lvl));
  assign tx_hit    = !idle_gate && !dir_rx && (count < CW'(cfg.lo_lvl));

  assign dma_rx_req  = rx_hit &&  cfg.rx_dma;
  assign st_rx_level = rx_hit && !cfg.rx_dma;
  assign dma_tx_req  = tx_hit &&  cfg.tx_dma;
  assign st_tx_level = tx_hit && !cfg.tx_dma;

  // R5
  rx_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dma_rx_req && st_rx_level));

  // R6
  tx_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dma_tx_req && st_tx_level));

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_active && count == '0) |-> !(dma_rx_req || dma_tx_req || st_rx_level || st_tx_level));

  // R10
  one_direction_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !((dma_rx_req || st_rx_level) && (dma_tx_req || st_tx_level)));
endmodule

// File: rtl/tfifo_dma_buf.sv
module tfifo_dma_buf
  import tfifo_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xfer_active,
  input  logic             dir_rx,
  input  logic             cfg_we,
  input  logic [15:0]      cfg_wdata,
  output logic [15:0]      cfg_rdata,
  input  logic             hwr_valid,
  input  logic [WIDTH-1:0] hwr_data,
  output logic             hwr_ready,
  input  logic             hrd_en,
  output logic [WIDTH-1:0] hrd_data,
  input  logic             eng_push_valid,
  input  logic [WIDTH-1:0] eng_push_data,
  output logic             eng_push_ready,
  output logic             eng_pop_valid,
  output logic [WIDTH-1:0] eng_pop_data,
  input  logic             eng_pop_ready,
  output logic             dma_rx_req,
  output logic             dma_tx_req,
  output logic             st_rx_level,
  output logic             st_tx_level
);
  localparam int CW = $clog2(DEPTH) + 1;

  buf_cfg_t         cfg;
  logic [CW-1:0]    count;
  logic             full;
  logic             empty;
  logic             push_req;
  logic [WIDTH-1:0] push_data;
  logic             pop_req;
  logic [WIDTH-1:0] head;

  // Direction routing: transmit = host fills, engine drains; receive = reverse.
  assign push_req  = dir_rx ? eng_push_valid : hwr_valid;
  assign push_data = dir_rx ? eng_push_data  : hwr_data;
  assign pop_req   = dir_rx ? hrd_en         : eng_pop_ready;

  assign hwr_ready      = !dir_rx && !full;
  assign eng_push_ready =  dir_rx && !full;
  assign eng_pop_valid  = !dir_rx && !empty;
  assign eng_pop_data   = head;
  assign hrd_data       = head;

  tfifo_cfg #(.DEPTH(DEPTH)) u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .cfg   (cfg),
    .rdata (cfg_rdata)
  );

  tfifo_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_req  (push_req),
    .push_data (push_data),
    .pop_req   (pop_req),
    .head_data (head),
    .count     (count),
    .full      (full),
    .empty     (empty)
  );

  tfifo_level #(.DEPTH(DEPTH)) u_level (
    .clk         (clk),
    .rst_n       (rst_n),
    .count       (count),
    .cfg         (cfg),
    .xfer_active (xfer_active),
    .dir_rx      (dir_rx),
    .dma_rx_req  (dma_rx_req),
    .dma_tx_req  (dma_tx_req),
    .st_rx_level (st_rx_level),
    .st_tx_level (st_tx_level)
  );

  // R10
  tx_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dir_rx |-> (!hwr_ready && !eng_pop_valid));
endmodule

// File: tb/tfifo_dma_buf_bench.sv
module tfifo_dma_buf_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xfer_active = 1'b0, dir_rx = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        hwr_valid = 1'b0;
  logic [15:0] hwr_data = '0;
  logic        hwr_ready;
  logic        hrd_en = 1'b0;
  logic [15:0] hrd_data;
  logic        eng_push_valid = 1'b0;
  logic [15:0] eng_push_data = '0;
  logic        eng_push_ready, eng_pop_valid;
  logic [15:0] eng_pop_data;
  logic        eng_pop_ready = 1'b0;
  logic        dma_rx_req, dma_tx_req, st_rx_level, st_tx_level;

  always #5 clk = ~clk;

  tfifo_dma_buf u_tfifo_dma_buf (.*);

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [15:0] m_mem [32];
  int m_cnt = 0, m_start = 0;
  bit m_rxen = 0, m_txen = 0;
  int m_hi = 31, m_lo = 0;
  logic [15:0] seq = 16'h3a00;

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_levels(string req);
    bit gate, rxh, txh;
    logic [3:0] exp, act;
    gate = !xfer_active && (m_cnt == 0);
    rxh  = !gate && dir_rx && (m_cnt > m_hi);
    txh  = !gate && !dir_rx && (m_cnt < m_lo);
    exp  = {rxh && m_rxen, rxh && !m_rxen, txh && m_txen, txh && !m_txen};
    act  = {dma_rx_req, st_rx_level, dma_tx_req, st_tx_level};
    chk(act == exp, req, 32'(act), 32'(exp));
  endtask

  task automatic cfg_write(bit rxe, int hi, bit txe, int lo);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = {rxe, 2'b00, 5'(hi), txe, 2'b00, 5'(lo)};
    @(negedge clk);
    cfg_we = 1'b0;
    m_rxen = rxe; m_hi = hi; m_txen = txe; m_lo = lo;
    chk(cfg_rdata == {rxe, 2'b00, 5'(hi), txe, 2'b00, 5'(lo)}, "R8 readback",
        32'(cfg_rdata), 32'({rxe, 2'b00, 5'(hi), txe, 2'b00, 5'(lo)}));
  endtask

  task automatic m_push(logic [15:0] d);
    m_mem[(m_start + m_cnt) % 32] = d;
    m_cnt++;
  endtask

  // transmit side: host pushes
  task automatic host_push(string req);
    bit acc;
    seq = seq * 16'd5 + 16'h0131;
    @(negedge clk);
    hwr_valid = 1'b1; hwr_data = seq;
    #1 acc = hwr_ready;
    chk(acc == (m_cnt < 32 && !dir_rx), req, 32'(acc), 32'(m_cnt < 32));
    @(negedge clk);
    hwr_valid = 1'b0;
    if (acc) m_push(seq);
  endtask

  // transmit side: engine pops
  task automatic eng_pop(string req);
    @(negedge clk);
    eng_pop_ready = 1'b1;
    #1;
    chk(eng_pop_valid == (m_cnt > 0), {req, " valid"}, 32'(eng_pop_valid), 32'(m_cnt > 0));
    if (m_cnt > 0)
      chk(eng_pop_data == m_mem[m_start], {req, " order"}, 32'(eng_pop_data), 32'(m_mem[m_start]));
    @(negedge clk);
    eng_pop_ready = 1'b0;
    if (m_cnt > 0) begin m_start = (m_start + 1) % 32; m_cnt--; end
  endtask

  task automatic eng_push(string req);
    bit acc;
    seq = seq * 16'd5 + 16'h0131;
    @(negedge clk);
    eng_push_valid = 1'b1; eng_push_data = seq;
    #1 acc = eng_push_ready;
    chk(acc == (m_cnt < 32), req, 32'(acc), 32'(m_cnt < 32));
    @(negedge clk);
    eng_push_valid = 1'b0;
    if (acc) m_push(seq);
  endtask

  task automatic host_read(string req);
    @(negedge clk);
    hrd_en = 1'b1;
    #1 chk(hrd_data == m_mem[m_start], req, 32'(hrd_data), 32'(m_mem[m_start]));
    @(negedge clk);
    hrd_en = 1'b0;
    if (m_cnt > 0) begin m_start = (m_start + 1) % 32; m_cnt--; end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    int los[4] = '{0, 5, 16, 31};
    int his[4] = '{0, 10, 20, 31};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cfg_rdata == 16'h1F00, "R1 cfg", 32'(cfg_rdata), 32'h1F00);
    chk(eng_pop_valid == 1'b0 && hwr_ready == 1'b1, "R1 empty",
        32'({eng_pop_valid, hwr_ready}), 32'b01);
    chk_levels("R1 levels");

    // R7 idle gate with a lower level that would otherwise fire
    cfg_write(0, 31, 0, 31);
    chk_levels("R7 idle empty");
    xfer_active = 1'b1;
    @(negedge clk);
    chk(st_tx_level == 1'b1, "R7 active", 32'(st_tx_level), 32'd1);
    // R8 setting the enable moves the flag to the DMA line
    cfg_write(0, 31, 1, 31);
    chk_levels("R8 enable clears flag");

    // offset ring head so the sweeps wrap (R2)
    for (int i = 0; i < 5; i++) host_push("R2 prelude");
    for (int i = 0; i < 5; i++) eng_pop("R2 prelude");

    // transmit sweeps (R6, R2, R3, R10)
    foreach (los[k]) begin
      for (int e = 0; e < 2; e++) begin
        cfg_write(0, 31, e[0], los[k]);
        chk_levels("R6 start");
        for (int n = 0; n < 32; n++) begin
          host_push("R10 tx push");
          chk_levels("R6 fill");
        end
        host_push("R3 full push ignored");
        chk_levels("R3 count held");
        // receive-side inputs have no effect in transmit (R10)
        @(negedge clk);
        eng_push_valid = 1'b1; hrd_en = 1'b1;
        #1 chk(eng_push_ready == 1'b0, "R10 eng push blocked", 32'(eng_push_ready), 32'd0);
        @(negedge clk);
        eng_push_valid = 1'b0; hrd_en = 1'b0;
        for (int n = 0; n < 32; n++) begin
          eng_pop("R2 tx drain");
          chk_levels("R6 drain");
        end
      end
    end

    // R9 simultaneous push and pop at occupancy 3
    cfg_write(0, 31, 0, 4);
    for (int i = 0; i < 3; i++) host_push("R9 setup");
    chk(st_tx_level == 1'b1, "R9 before", 32'(st_tx_level), 32'd1);
    seq = seq + 16'h0777;
    @(negedge clk);
    hwr_valid = 1'b1; hwr_data = seq; eng_pop_ready = 1'b1;
    #1 chk(eng_pop_data == m_mem[m_start], "R9 head", 32'(eng_pop_data), 32'(m_mem[m_start]));
    @(negedge clk);
    hwr_valid = 1'b0; eng_pop_ready = 1'b0;
    m_start = (m_start + 1) % 32; m_cnt--; m_push(seq);
    chk_levels("R9 count unchanged");
    for (int i = 0; i < 3; i++) eng_pop("R9 order");

    // receive sweeps (R5, R2, R4, R10)
    dir_rx = 1'b1;
    foreach (his[k]) begin
      for (int e = 0; e < 2; e++) begin
        cfg_write(e[0], his[k], 0, 0);
        for (int n = 0; n < 33; n++) begin
          eng_push("R10 rx push");
          chk_levels("R5 fill");
        end
        for (int n = 0; n < 32; n++) begin
          host_read("R2 rx drain");
          chk_levels("R5 drain");
        end
        host_read("R4 empty read");
        host_read("R4 empty read repeat");
        chk_levels("R4 still empty");
      end
    end

    // R7 idle in receive with high level 0, empty then one entry
    cfg_write(0, 0, 0, 0);
    xfer_active = 1'b0;
    @(negedge clk);
    chk_levels("R7 rx idle");
    eng_push("R7 push");
    chk_levels("R7 nonempty overrides idle");
    finish_run();
  end
endmodule